// File: doc/BRIEF.md
# Bidirectional Port with Timer-Overridable Top Bit

This block is one 8-bit peripheral port of a parallel interface unit. It keeps a stored output value and a per-pin direction mask, both reached through a small register bus with a 4-bit offset. Each pin is presented to the outside as a separate data bit and output-enable bit, so the pad tristate is built outside the block. Reading the port returns a mix: the live pin level for input pins and the effective output value for output pins.

The top pin has a second, independent driver. When the override input is high, the pin takes the level supplied by the timer block and is driven as an output, whatever its direction bit holds. The stored output bit is left untouched and comes back once the override is removed. The readback uses the timer level in place of the stored bit, under the direction mask.

Every access to the port register sends a clear request to the interrupt block for the port's two handshake edge flags. A read clears both flags. A write clears the first flag, and clears the second only when the keep input from the peripheral control is low.

Top module: `dual_source_port`

## Requirements
- R1: Under synchronous reset the stored output value and the direction mask become 0x00. `pin_out`, `pin_oe`, `bus_rdata`, `clr_flag1` and `clr_flag2` are all 0 on the cycle after reset.
- R2: A write at offset 0x0 stores `bus_wdata` as the output value. After the second rising edge from the write strobe, `pin_out` shows that value. Bit 7 is excepted while the override is active.
- R3: A write at offset 0x2 stores the direction mask, where a 1 makes the pin an output. After the second rising edge from the strobe, `pin_oe` equals the mask.
- R4: A read at offset 0x0 loads `bus_rdata` at the strobe's rising edge with (pin_in AND NOT mask) OR (effective output AND mask).
- R5: A read at offset 0x2 loads `bus_rdata` with the direction mask.
- R6: While `ovr_en` is high, `pin_out[7]` follows `ovr_level` one edge later. The stored bit 7 is kept and reappears on `pin_out[7]` once `ovr_en` falls.
- R7: While `ovr_en` is high, `pin_oe[7]` is 1 one edge later, even when direction bit 7 is 0.
- R8: During override, the effective output bit 7 used by the port readback is `ovr_level`. It shows in `bus_rdata[7]` only when direction bit 7 is 1; otherwise `pin_in[7]` shows.
- R9: A write at offset 0x0 raises `clr_flag1` for exactly the one cycle after the strobe edge. `clr_flag2` rises in the same cycle only if `keep_flag2` is low.
- R10: A read at offset 0x0 raises both `clr_flag1` and `clr_flag2` for exactly the one cycle after the strobe edge.
- R11: Accesses at any offset other than 0x0 and 0x2 change no state and make no clear request. Reads there return 0x00. Accesses at offset 0x2 make no clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held between reads |
| pin_in | input | 8 | Live pin levels |
| pin_out | output | 8 | Pin drive data, registered |
| pin_oe | output | 8 | Pin output enables, registered |
| ovr_en | input | 1 | Timer takes over pin 7 |
| ovr_level | input | 1 | Level the timer puts on pin 7 |
| keep_flag2 | input | 1 | When high, port writes leave the second edge flag alone |
| clr_flag1 | output | 1 | Clear request for the first handshake edge flag |
| clr_flag2 | output | 1 | Clear request for the second handshake edge flag |

## Verification
Read data and clear requests are due one rising edge after the access strobe. The bench samples both at the falling edge that follows that edge. Pin data and enables pass through the storage register and then the output register, so they are due two edges after a bus write. They are sampled at the second falling edge, after the clear requests have been checked to be low again. Changes on the override inputs are applied before the access cycle of each step, so they have settled by the time the pins are compared.

// File: rtl/dsport_pkg.sv
package dsport_pkg;

  // Decoded access kinds for one bus cycle.
  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic dir_wr;
    logic dir_rd;
  } dsport_acc_t;

  localparam dsport_acc_t ACC_IDLE = '{default: 1'b0};

endpackage

// File: rtl/dsport_regs.sv
module dsport_regs
  import dsport_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned DIR_OFS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [WIDTH-1:0]  wdata,
  output dsport_acc_t       acc,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFS);

  logic hit_data;
  logic hit_dir;

  always_comb begin
    hit_data     = (addr == A_DATA);
    hit_dir      = (addr == A_DIR);
    acc          = ACC_IDLE;
    acc.data_wr  = wr && hit_data;
    acc.dir_wr   = wr && hit_dir;
    acc.data_rd  = rd && !wr && hit_data;
    acc.dir_rd   = rd && !wr && hit_dir;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (acc.data_wr) out_q <= wdata;
      if (acc.dir_wr)  dir_q <= wdata;
    end
  end

  // R3 / R11: the mask only changes through its own offset.
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_DIR) |=> $stable(dir_q));

  // R2 / R11: the output value only changes through its own offset.
  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_DATA) |=> $stable(out_q));

endmodule

// File: rtl/dsport_drive.sv
module dsport_drive #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned OVR_BIT = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic             ovr_en,
  input  logic             ovr_level,
  output logic [WIDTH-1:0] eff_out,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  logic [WIDTH-1:0] eff_oe;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b == OVR_BIT) begin : g_shared
      assign eff_out[b] = ovr_en ? ovr_level : out_q[b];
      assign eff_oe[b]  = ovr_en | dir_q[b];
    end else begin : g_plain
      assign eff_out[b] = out_q[b];
      assign eff_oe[b]  = dir_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= eff_out;
      pin_oe  <= eff_oe;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  p_ovr_oe_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ovr_en) |-> pin_oe[OVR_BIT]);

  p_ovr_level_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ovr_en) |-> (pin_out[OVR_BIT] == $past(ovr_level)));

  p_plain_oe_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(ovr_en) |-> (pin_oe == $past(dir_q)));

endmodule

// File: rtl/dsport_readback.sv
module dsport_readback
  import dsport_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dsport_acc_t      acc,
  input  logic             rd,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] eff_out,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mixed;
  logic [WIDTH-1:0] sel;

  always_comb begin
    mixed = (pin_in & ~dir_q) | (eff_out & dir_q);
    if (acc.data_rd)     sel = mixed;
    else if (acc.dir_rd) sel = dir_q;
    else                 sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  p_rd_other_r11: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd) && !$past(acc.data_rd) && !$past(acc.dir_rd)) |-> (rdata == '0));

  p_rd_dir_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(acc.dir_rd) |-> (rdata == $past(dir_q)));

endmodule

// File: rtl/dsport_flagclr.sv
module dsport_flagclr
  import dsport_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dsport_acc_t acc,
  input  logic        keep_flag2,
  output logic        clr_flag1,
  output logic        clr_flag2
);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_flag1 <= 1'b0;
      clr_flag2 <= 1'b0;
    end else begin
      clr_flag1 <= acc.data_wr | acc.data_rd;
      clr_flag2 <= acc.data_rd | (acc.data_wr & ~keep_flag2);
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  p_clr1_cause_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    clr_flag1 |-> ($past(acc.data_wr) || $past(acc.data_rd)));

  p_clr2_keep_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    (clr_flag2 && !$past(acc.data_rd)) |-> !$past(keep_flag2));

  p_clr2_read_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(acc.data_rd) |-> (clr_flag1 && clr_flag2));

endmodule

// File: rtl/dual_source_port.sv
module dual_source_port
  import dsport_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned DIR_OFS  = 2,
  parameter int unsigned OVR_BIT  = WIDTH - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic              ovr_en,
  input  logic              ovr_level,
  input  logic              keep_flag2,
  output logic              clr_flag1,
  output logic              clr_flag2
);

  dsport_acc_t      acc;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] eff_out;

  dsport_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .acc(acc), .out_q(out_q), .dir_q(dir_q)
  );

  dsport_drive #(.WIDTH(WIDTH), .OVR_BIT(OVR_BIT)) u_drive (
    .clk(clk), .rst(rst), .out_q(out_q), .dir_q(dir_q),
    .ovr_en(ovr_en), .ovr_level(ovr_level),
    .eff_out(eff_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  dsport_readback #(.WIDTH(WIDTH)) u_readback (
    .clk(clk), .rst(rst), .acc(acc), .rd(bus_rd), .pin_in(pin_in),
    .eff_out(eff_out), .dir_q(dir_q), .rdata(bus_rdata)
  );

  dsport_flagclr u_flagclr (
    .clk(clk), .rst(rst), .acc(acc), .keep_flag2(keep_flag2),
    .clr_flag1(clr_flag1), .clr_flag2(clr_flag2)
  );

  // R1: nothing is driven or requested on the cycle after reset.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !clr_flag1 && !clr_flag2));

endmodule

// File: tb/dual_source_port_bench.sv
module dual_source_port_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       ovr_en = 1'b0;
  logic       ovr_level = 1'b0;
  logic       keep_flag2 = 1'b0;
  logic       clr_flag1;
  logic       clr_flag2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_out = '0;
  logic [7:0] m_dir = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_source_port u_dual_source_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ovr_en(ovr_en), .ovr_level(ovr_level),
    .keep_flag2(keep_flag2), .clr_flag1(clr_flag1), .clr_flag2(clr_flag2)
  );

  function automatic logic [7:0] exp_eff();
    logic [7:0] e = m_out;
    if (ovr_en) e[7] = ovr_level;
    return e;
  endfunction

  function automatic logic [7:0] exp_oe();
    return m_dir | {ovr_en, 7'b0};
  endfunction

  function automatic logic [7:0] exp_port_read();
    return (pin_in & ~m_dir) | (exp_eff() & m_dir);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One bus step: issue at a falling edge, check results one and two edges later.
  task automatic step(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d,
                      input string tag);
    logic e1, e2, is_data;
    logic [7:0] erd;
    is_data = (a == 4'h0);
    e1 = is_data && (w || r);
    e2 = is_data && (r || (w && !keep_flag2));
    erd = (a == 4'h0) ? exp_port_read() : (a == 4'h2) ? m_dir : 8'h00;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    chk({tag, " R9/R10/R11 clr1"}, {7'b0, clr_flag1}, {7'b0, e1});
    chk({tag, " R9/R10/R11 clr2"}, {7'b0, clr_flag2}, {7'b0, e2});
    if (r) chk({tag, " R4/R5/R8/R11 rdata"}, bus_rdata, erd);
    if (w && a == 4'h0) m_out = d;
    if (w && a == 4'h2) m_dir = d;
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    chk({tag, " R9 pulse width"}, {6'b0, clr_flag1, clr_flag2}, 8'h00);
    chk({tag, " R2/R6 pin_out"}, pin_out, exp_eff());
    chk({tag, " R3/R7 pin_oe"}, pin_oe, exp_oe());
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 clr", {6'b0, clr_flag1, clr_flag2}, 8'h00);
    pin_in = 8'hA3;
    step(4'h2, 0, 1, 0, "R1 dir after reset");
    step(4'h0, 0, 1, 0, "R1 all inputs");

    step(4'h2, 1, 0, 8'hFF, "R3 dir all out");
    step(4'h0, 1, 0, 8'h55, "R2 out 55");
    step(4'h0, 0, 1, 0, "R4 read out");
    ovr_en = 1; ovr_level = 1;
    step(4'h0, 0, 1, 0, "R6/R8 ovr high");
    ovr_level = 0;
    step(4'h0, 1, 0, 8'hFF, "R6 write under ovr");
    step(4'h0, 0, 1, 0, "R8 ovr low");
    ovr_en = 0;
    step(4'h2, 0, 1, 0, "R6 stored bit back");
    step(4'h2, 1, 0, 8'h0F, "R3 dir low nibble");
    ovr_en = 1; ovr_level = 1; pin_in = 8'h30;
    step(4'h0, 0, 1, 0, "R7/R8 ovr dir7=0");
    keep_flag2 = 1;
    step(4'h0, 1, 0, 8'h12, "R9 keep");
    keep_flag2 = 0;
    step(4'h0, 1, 0, 8'h34, "R9 no keep");
    step(4'h5, 1, 0, 8'hEE, "R11 write other");
    step(4'h5, 0, 1, 0, "R11 read other");
    step(4'h0, 0, 1, 0, "R11 state intact");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic w;
      int k = $urandom_range(0, 9);
      a = (k < 4) ? 4'h0 : (k < 7) ? 4'h2 : 4'($urandom_range(0, 15));
      w = $urandom_range(0, 1) == 1;
      pin_in = 8'($urandom);
      ovr_en = $urandom_range(0, 2) == 0;
      ovr_level = $urandom_range(0, 1) == 1;
      keep_flag2 = $urandom_range(0, 1) == 1;
      step(a, w, !w, 8'($urandom), "rand R2/R4/R9/R10");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule